// File: doc/BRIEF.md
# Silicon Strip Hit Clusterer with Road Filter

This block takes digitized hits from eight silicon readout channels on one shared, handshaked stream. Each hit names its channel, the readout chip within that channel, its strip number and an 8-bit ADC amplitude. The block corrects the amplitude with pedestal and gain tables kept for each chip. It discards strips that a mask table marks as bad, and it treats corrected amplitudes under a programmable floor as empty strips. Surviving hits on consecutive strips of one channel merge into a cluster. The block tracks a separate open cluster for every channel, so the channels can interleave freely on the stream.

When a cluster closes, the block forms an amplitude-weighted centroid with two fractional bits. The weights come from at most five strips, counted from the strip where the cluster began. The integer strip of the centroid indexes a road lookup table, which returns a road bin. That bin is compared against a small list of track roads supplied from outside. A cluster that matches no road is dropped. A matching cluster leaves on the output with its channel, its centroid and the index of the matching road.

An end-of-event strobe sweeps through all channels, one per cycle, and closes whatever clusters are still open. The tables are filled through a simple write port before use.

Top module: `clus_road_top`

## Requirements
- R1: The corrected amplitude is min(255, (max(adc - ped, 0) * gain) >> 4). Here ped and gain are the 8-bit table entries at address channel*4 + chip, written with select 0 (pedestal) and select 1 (gain); gain has 4 fractional bits.
- R2: A hit whose corrected amplitude is zero or below `min_amp_i` is treated as an empty strip. It neither opens, extends nor closes a cluster.
- R3: A hit is also treated as an empty strip when bit 0 of the mask entry at address channel*128 + strip is 1. Mask entries are written with select 2.
- R4: A valid hit on strip last+1 of the channel's open cluster extends that cluster. Any other valid hit closes the open cluster, if there is one, and starts a new cluster at its own strip.
- R5: The output centroid is floor(4 * sum(a*s) / sum(a)), where s is the strip and a the corrected amplitude, taken over at most the first five strips of the cluster.
- R6: The road bin is the 4-bit road table entry (select 2'b11, address = strip) at the integer part of the centroid. The cluster is emitted with the lowest road index r for which `road_valid_i[r]` is set and bits [4r+3:4r] of `road_bin_i` equal that bin. With no such road, nothing is emitted.
- R7: An accepted `eoe_i` drops `hit_ready_o` for exactly 8 cycles. During those cycles channels 0 to 7 are closed in ascending order, one per cycle, and each emits its open cluster subject to R6.
- R8: Hits on one channel never close or alter the cluster of another channel.
- R9: After reset, `hit_ready_o` is 1 and `out_valid_o` is 0. A cluster closed by a hit accepted at a clock edge, or by a sweep step at an edge, appears on the output for one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_amp_i | input | 8 | Minimum corrected amplitude counted as a hit |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Table select: 0 pedestal, 1 gain, 2 bad-strip mask, 3 road table |
| cfg_addr_i | input | 10 | Table address |
| cfg_data_i | input | 8 | Table write data |
| hit_valid_i | input | 1 | Hit present |
| hit_ready_o | output | 1 | Hit or end-of-event can be accepted |
| hit_ch_i | input | 3 | Readout channel of the hit |
| hit_chip_i | input | 2 | Readout chip within the channel |
| hit_strip_i | input | 7 | Strip number within the channel |
| hit_adc_i | input | 8 | Raw amplitude |
| eoe_i | input | 1 | End of event, taken when `hit_ready_o` is 1 |
| road_valid_i | input | 4 | One valid flag per road |
| road_bin_i | input | 16 | Four 4-bit road bins |
| out_valid_o | output | 1 | Cluster output valid |
| out_ch_o | output | 3 | Channel of the emitted cluster |
| out_cent_o | output | 9 | Centroid, strip units with 2 fractional bits |
| out_road_o | output | 2 | Index of the matching road |

## Verification
The bench sweeps the raw amplitude of a leading strip across its whole range, for chips with different pedestal and gain. This exposes a wrong clamp, a wrong gain shift or a wrong floor, because each of those moves the centroid of a two-strip cluster or splits the cluster into a single strip. A masked strip placed between two live strips must split them into two clusters; a design that ignored the mask would emit one merged cluster instead. A seven-strip cluster catches a window that weights more than five strips. Roads sharing a bin, and a disabled road, catch wrong priority or a valid flag that is ignored. Interleaved channels followed by the end-of-event sweep catch cross-channel closing, a sweep that skips or reorders channels, and a ready signal held low for the wrong number of cycles.

// File: rtl/clus_pkg.sv
package clus_pkg;
    localparam int ADC_W   = 8;
    localparam int STRIP_W = 7;
    localparam int CHIP_W  = 2;
    localparam int WIN_W   = 3;
    localparam int GAIN_FR = 4;
    localparam int SA_W    = ADC_W + WIN_W;
    localparam int SAS_W   = ADC_W + STRIP_W + WIN_W;
    localparam int CENT_W  = STRIP_W + 2;

    typedef enum logic [1:0] {
        CFG_PED  = 2'd0,
        CFG_GAIN = 2'd1,
        CFG_BAD  = 2'd2,
        CFG_ROAD = 2'd3
    } cfg_sel_e;

    // open cluster record kept per channel
    typedef struct packed {
        logic               active;
        logic [STRIP_W-1:0] last;
        logic [WIN_W-1:0]   cnt;
        logic [SA_W-1:0]    sa;
        logic [SAS_W-1:0]   sas;
    } clus_t;
endpackage

// File: rtl/clus_cal.sv
module clus_cal
    import clus_pkg::*;
#(
    parameter int CH_W = 3,
    localparam int CI_W   = CH_W + CHIP_W,
    localparam int NCHIP  = 1 << CI_W,
    localparam int AW     = CH_W + STRIP_W,
    localparam int NSTRIP = 1 << AW
) (
    input  logic               clk,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [ADC_W-1:0]   cfg_data_i,
    input  logic [CH_W-1:0]    ch_i,
    input  logic [CHIP_W-1:0]  chip_i,
    input  logic [STRIP_W-1:0] strip_i,
    input  logic [ADC_W-1:0]   adc_i,
    output logic [ADC_W-1:0]   corr_o,
    output logic               bad_o
);
    logic [ADC_W-1:0] ped_mem  [NCHIP];
    logic [ADC_W-1:0] gain_mem [NCHIP];
    logic [NSTRIP-1:0] bad_mem;

    always_ff @(posedge clk) begin
        if (cfg_we_i && cfg_sel_i == CFG_PED)  ped_mem[cfg_addr_i[CI_W-1:0]]  <= cfg_data_i;
        if (cfg_we_i && cfg_sel_i == CFG_GAIN) gain_mem[cfg_addr_i[CI_W-1:0]] <= cfg_data_i;
        if (cfg_we_i && cfg_sel_i == CFG_BAD)  bad_mem[cfg_addr_i]            <= cfg_data_i[0];
    end

    logic [CI_W-1:0]      cidx;
    logic [ADC_W-1:0]     ped, diff;
    logic [2*ADC_W-1:0]   prod;
    logic [2*ADC_W-GAIN_FR-1:0] scaled;

    always_comb begin
        cidx   = {ch_i, chip_i};
        ped    = ped_mem[cidx];
        diff   = (adc_i > ped) ? adc_i - ped : '0;
        prod   = (2*ADC_W)'(diff) * (2*ADC_W)'(gain_mem[cidx]);
        scaled = prod[2*ADC_W-1:GAIN_FR];
        corr_o = (scaled > (2*ADC_W-GAIN_FR)'({ADC_W{1'b1}})) ? {ADC_W{1'b1}} : scaled[ADC_W-1:0];
        bad_o  = bad_mem[{ch_i, strip_i}];
    end
endmodule

// File: rtl/clus_road.sv
module clus_road
    import clus_pkg::*;
#(
    parameter int NUM_ROADS = 4,
    parameter int BIN_W     = 4,
    localparam int RI_W     = $clog2(NUM_ROADS)
) (
    input  logic                       clk,
    input  logic                       cfg_we_i,
    input  logic [STRIP_W-1:0]         cfg_addr_i,
    input  logic [BIN_W-1:0]           cfg_data_i,
    input  logic [STRIP_W-1:0]         strip_i,
    input  logic [NUM_ROADS-1:0]       road_valid_i,
    input  logic [NUM_ROADS*BIN_W-1:0] road_bin_i,
    output logic                       match_o,
    output logic [RI_W-1:0]            idx_o
);
    logic [BIN_W-1:0] lut [1 << STRIP_W];
    logic [BIN_W-1:0] bin;

    always_ff @(posedge clk) begin
        if (cfg_we_i) lut[cfg_addr_i] <= cfg_data_i;
    end

    // scan from the top so the lowest matching index wins
    always_comb begin
        bin     = lut[strip_i];
        match_o = 1'b0;
        idx_o   = '0;
        for (int r = NUM_ROADS - 1; r >= 0; r--) begin
            if (road_valid_i[r] && road_bin_i[r*BIN_W +: BIN_W] == bin) begin
                match_o = 1'b1;
                idx_o   = RI_W'(r);
            end
        end
    end
endmodule

// File: rtl/clus_road_top.sv
module clus_road_top
    import clus_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_ROADS = 4,
    parameter int BIN_W     = 4,
    parameter int WIN       = 5,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int RI_W     = $clog2(NUM_ROADS),
    localparam int CFG_AW   = CH_W + STRIP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADC_W-1:0]           min_amp_i,
    input  logic                       cfg_we_i,
    input  logic [1:0]                 cfg_sel_i,
    input  logic [CFG_AW-1:0]          cfg_addr_i,
    input  logic [ADC_W-1:0]           cfg_data_i,
    input  logic                       hit_valid_i,
    output logic                       hit_ready_o,
    input  logic [CH_W-1:0]            hit_ch_i,
    input  logic [CHIP_W-1:0]          hit_chip_i,
    input  logic [STRIP_W-1:0]         hit_strip_i,
    input  logic [ADC_W-1:0]           hit_adc_i,
    input  logic                       eoe_i,
    input  logic [NUM_ROADS-1:0]       road_valid_i,
    input  logic [NUM_ROADS*BIN_W-1:0] road_bin_i,
    output logic                       out_valid_o,
    output logic [CH_W-1:0]            out_ch_o,
    output logic [CENT_W-1:0]          out_cent_o,
    output logic [RI_W-1:0]            out_road_o
);
    typedef struct packed {
        clus_t [NUM_CH-1:0] cl;
        logic               flush;
        logic [CH_W-1:0]    fch;
        logic               ov;
        logic [CH_W-1:0]    och;
        logic [CENT_W-1:0]  ocent;
        logic [RI_W-1:0]    oroad;
    } st_t;

    st_t s_q, s_d;

    logic [ADC_W-1:0]  corr;
    logic              bad;
    logic              acc, good, adj, close_v, match;
    logic [CH_W-1:0]   close_ch;
    logic [RI_W-1:0]   ridx;
    clus_t             cur, fl, cls;
    logic [SAS_W-1:0]  prod;
    logic [CENT_W-1:0] cent;
    logic [SAS_W+1:0]  den;

    clus_cal #(.CH_W(CH_W)) u_cal (
        .clk       (clk),
        .cfg_we_i  (cfg_we_i),
        .cfg_sel_i (cfg_sel_i),
        .cfg_addr_i(cfg_addr_i),
        .cfg_data_i(cfg_data_i),
        .ch_i      (hit_ch_i),
        .chip_i    (hit_chip_i),
        .strip_i   (hit_strip_i),
        .adc_i     (hit_adc_i),
        .corr_o    (corr),
        .bad_o     (bad)
    );

    clus_road #(.NUM_ROADS(NUM_ROADS), .BIN_W(BIN_W)) u_road (
        .clk         (clk),
        .cfg_we_i    (cfg_we_i && cfg_sel_i == CFG_ROAD),
        .cfg_addr_i  (cfg_addr_i[STRIP_W-1:0]),
        .cfg_data_i  (cfg_data_i[BIN_W-1:0]),
        .strip_i     (cent[CENT_W-1:2]),
        .road_valid_i(road_valid_i),
        .road_bin_i  (road_bin_i),
        .match_o     (match),
        .idx_o       (ridx)
    );

    // which cluster, if any, closes this cycle
    always_comb begin
        cur  = s_q.cl[hit_ch_i];
        fl   = s_q.cl[s_q.fch];
        acc  = hit_valid_i && !s_q.flush;
        good = acc && !bad && (corr != '0) && (corr >= min_amp_i);
        adj  = cur.active && ({1'b0, hit_strip_i} == {1'b0, cur.last} + 1'b1);
        prod = SAS_W'(corr) * SAS_W'(hit_strip_i);
        close_v  = 1'b0;
        close_ch = '0;
        cls      = '0;
        if (s_q.flush) begin
            close_v  = fl.active;
            close_ch = s_q.fch;
            cls      = fl;
        end else if (good && !adj && cur.active) begin
            close_v  = 1'b1;
            close_ch = hit_ch_i;
            cls      = cur;
        end
        den  = (cls.sa == '0) ? (SAS_W+2)'(1) : (SAS_W+2)'(cls.sa);
        cent = CENT_W'({cls.sas, 2'b00} / den);
    end

    always_comb begin
        s_d       = s_q;
        s_d.ov    = close_v && match;
        s_d.och   = close_ch;
        s_d.ocent = cent;
        s_d.oroad = ridx;
        if (good) begin
            if (adj) begin
                s_d.cl[hit_ch_i].last = hit_strip_i;
                if (cur.cnt < WIN_W'(WIN)) begin
                    s_d.cl[hit_ch_i].cnt = cur.cnt + 1'b1;
                    s_d.cl[hit_ch_i].sa  = cur.sa + SA_W'(corr);
                    s_d.cl[hit_ch_i].sas = cur.sas + prod;
                end
            end else begin
                s_d.cl[hit_ch_i].active = 1'b1;
                s_d.cl[hit_ch_i].last   = hit_strip_i;
                s_d.cl[hit_ch_i].cnt    = WIN_W'(1);
                s_d.cl[hit_ch_i].sa     = SA_W'(corr);
                s_d.cl[hit_ch_i].sas    = prod;
            end
        end
        if (s_q.flush) begin
            s_d.cl[s_q.fch].active = 1'b0;
            if (s_q.fch == CH_W'(NUM_CH - 1)) s_d.flush = 1'b0;
            else                              s_d.fch   = s_q.fch + 1'b1;
        end else if (eoe_i) begin
            s_d.flush = 1'b1;
            s_d.fch   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_ready_o = !s_q.flush;
    assign out_valid_o = s_q.ov;
    assign out_ch_o    = s_q.och;
    assign out_cent_o  = s_q.ocent;
    assign out_road_o  = s_q.oroad;
endmodule

// File: rtl/clus_road_chk.sv
module clus_road_chk #(
    parameter int NUM_CH    = 8,
    parameter int NUM_ROADS = 4,
    parameter int RI_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hit_valid_i,
    input logic                 hit_ready_o,
    input logic                 eoe_i,
    input logic [NUM_ROADS-1:0] road_valid_i,
    input logic                 out_valid_o,
    input logic [RI_W-1:0]      out_road_o
);
    localparam int SC_W = $clog2(NUM_CH + 2) + 1;

    logic [SC_W-1:0]      stall_q;
    logic [NUM_ROADS-1:0] rv_q;

    always_ff @(posedge clk) begin
        rv_q <= road_valid_i;
        if (!rst_n || hit_ready_o)            stall_q <= '0;
        else if (stall_q != {SC_W{1'b1}})     stall_q <= stall_q + 1'b1;
    end

    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q <= SC_W'(NUM_CH)); // R7
    AST_EOE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ready_o && eoe_i) |=> !hit_ready_o); // R7
    AST_OUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ($past(hit_valid_i && hit_ready_o) || $past(!hit_ready_o))); // R9
    AST_ROAD_WAS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && $past(rst_n)) |-> rv_q[out_road_o]); // R6
endmodule

bind clus_road_top clus_road_chk #(
    .NUM_CH(NUM_CH), .NUM_ROADS(NUM_ROADS), .RI_W(RI_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid_i (hit_valid_i),
    .hit_ready_o (hit_ready_o),
    .eoe_i       (eoe_i),
    .road_valid_i(road_valid_i),
    .out_valid_o (out_valid_o),
    .out_road_o  (out_road_o)
);

// File: tb/sim_clus_road_top.sv
module sim_clus_road_top;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic [7:0]  min_amp = 8'd8;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [9:0]  cfg_addr = 0;
    logic [7:0]  cfg_data = 0;
    logic        hv = 0, eoe = 0;
    logic        hready;
    logic [2:0]  hch = 0;
    logic [1:0]  hchip = 0;
    logic [6:0]  hstrip = 0;
    logic [7:0]  hadc = 0;
    logic [3:0]  rvalid = 4'b1110;
    logic [15:0] rbin = {4'd2, 4'd5, 4'd2, 4'd9};
    logic        ov;
    logic [2:0]  och;
    logic [8:0]  ocent;
    logic [1:0]  oroad;

    int tests = 0, fails = 0, cycles = 0;

    clus_road_top u0 (
        .clk(clk), .rst_n(rst_n), .min_amp_i(min_amp),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .hit_valid_i(hv), .hit_ready_o(hready), .hit_ch_i(hch), .hit_chip_i(hchip),
        .hit_strip_i(hstrip), .hit_adc_i(hadc), .eoe_i(eoe),
        .road_valid_i(rvalid), .road_bin_i(rbin),
        .out_valid_o(ov), .out_ch_o(och), .out_cent_o(ocent), .out_road_o(oroad)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int ped(int ch, int chip); return ch + 3*chip; endfunction
    function automatic int gain(int chip); return 16 + 8*chip; endfunction
    function automatic int corr(int ch, int chip, int adc);
        int d = (adc > ped(ch, chip)) ? adc - ped(ch, chip) : 0;
        int v = (d * gain(chip)) >> 4;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic expect_out(input bit v, input int ch, input int cent, input int road, input string req);
        chk(ov == v, {req, " valid"}, int'(ov), int'(v));
        if (v && ov) begin
            chk(int'(och) == ch, {req, " channel"}, int'(och), ch);
            chk(int'(ocent) == cent, {req, " centroid"}, int'(ocent), cent);
            chk(int'(oroad) == road, {req, " road"}, int'(oroad), road);
        end
    endtask

    task automatic cfg(input int sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 10'(addr); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic hit(input int ch, input int chip, input int strip, input int adc);
        @(negedge clk);
        hv = 1; hch = 3'(ch); hchip = 2'(chip); hstrip = 7'(strip); hadc = 8'(adc);
        @(negedge clk);
        hv = 0;
    endtask

    task automatic sweep_eoe(output bit got [8], output int gcent [8], output int groad [8], output bit rdy [8]);
        @(negedge clk);
        eoe = 1;
        @(negedge clk);
        eoe = 0;
        chk(hready == 0, "R7 ready drops after end of event", int'(hready), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            got[i] = ov && (int'(och) == i);
            gcent[i] = int'(ocent);
            groad[i] = int'(oroad);
            rdy[i] = hready;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        bit got [8]; int gc [8]; int gr [8]; bit rdy [8];
        int c1, c2, exp, sa, sas;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(hready == 1, "R9 reset ready", int'(hready), 1);
        chk(ov == 0, "R9 reset out_valid", int'(ov), 0);
        rst_n = 1;

        for (int ch = 0; ch < 8; ch++)
            for (int chip = 0; chip < 4; chip++) begin
                cfg(0, ch*4 + chip, ped(ch, chip));
                cfg(1, ch*4 + chip, gain(chip));
            end
        for (int a = 0; a < 1024; a++) cfg(2, a, (a == 20) ? 1 : 0);
        for (int s = 0; s < 128; s++) cfg(3, s, s >> 3);

        // R7: empty sweep emits nothing, ready back after 8 cycles
        sweep_eoe(got, gc, gr, rdy);
        for (int i = 0; i < 8; i++) chk(got[i] == 0, "R7 empty sweep output", int'(got[i]), 0);
        chk(rdy[6] == 0 && rdy[7] == 1, "R7 ready timing", int'({rdy[6], rdy[7]}), 1);

        // R1 R2 R5: leading strip amplitude sweep on chips 0 and 1
        for (int chip = 0; chip < 2; chip++)
            for (int a = 0; a <= 255; a += 5) begin
                hit(0, chip, 18, a);
                expect_out(0, 0, 0, 0, "R4 no close on new start");
                hit(0, chip, 19, 120);
                hit(0, chip, 100, 50);
                c1 = corr(0, chip, a);
                c2 = corr(0, chip, 120);
                exp = (c1 >= 8) ? (4*(18*c1 + 19*c2)) / (c1 + c2) : 76;
                expect_out(1, 0, exp, 1, (c1 >= 8) ? "R1 R5 corrected weights" : "R2 below floor");
            end

        // R3: masked strip 20 splits the cluster
        hit(0, 0, 19, 60);
        hit(0, 0, 20, 60);
        expect_out(0, 0, 0, 0, "R3 masked strip");
        hit(0, 0, 21, 60);
        expect_out(1, 0, 76, 1, "R3 first part");
        hit(0, 0, 100, 60);
        expect_out(1, 0, 84, 1, "R3 second part");

        // R5: seven-strip cluster, only first five weighted
        sa = 0; sas = 0;
        for (int i = 0; i < 7; i++) begin
            hit(3, 0, 40 + i, 20 + 10*i);
            expect_out(0, 0, 0, 0, "R4 extension silent");
            if (i < 5) begin
                sa += corr(3, 0, 20 + 10*i);
                sas += corr(3, 0, 20 + 10*i) * (40 + i);
            end
        end
        hit(3, 0, 90, 50);
        expect_out(1, 3, (4*sas)/sa, 2, "R5 window of five");

        // R6: road with a disabled valid, then priority
        hit(3, 0, 74, 80);
        hit(3, 0, 120, 80);
        expect_out(0, 0, 0, 0, "R6 disabled road dropped");
        rvalid = 4'b1111;
        hit(3, 0, 74, 80);
        hit(3, 0, 122, 80);
        expect_out(1, 3, 296, 0, "R6 enabled road");
        rvalid = 4'b1000;
        hit(3, 0, 18, 80);
        hit(3, 0, 124, 80);
        expect_out(1, 3, 72, 3, "R6 single valid road");
        rvalid = 4'b1110;

        // clean all channels
        sweep_eoe(got, gc, gr, rdy);
        for (int i = 0; i < 8; i++) chk(got[i] == 0, "R7 no road sweep", int'(got[i]), 0);

        // R8: interleaved channels, R7 ordered sweep
        hit(1, 0, 18, 50);
        hit(2, 0, 40, 50);
        expect_out(0, 0, 0, 0, "R8 other channel untouched");
        hit(1, 0, 19, 50);
        hit(2, 0, 41, 100);
        expect_out(0, 0, 0, 0, "R8 interleaved extend");
        sweep_eoe(got, gc, gr, rdy);
        c1 = corr(1, 0, 50);
        chk(got[1] == 1 && gc[1] == (4*(18*c1 + 19*c1))/(2*c1) && gr[1] == 1,
            "R8 channel 1 cluster", gc[1], (4*(18*c1 + 19*c1))/(2*c1));
        c1 = corr(2, 0, 50);
        c2 = corr(2, 0, 100);
        exp = (4*(40*c1 + 41*c2)) / (c1 + c2);
        chk(got[2] == 1 && gc[2] == exp && gr[2] == 2, "R7 channel 2 in order", gc[2], exp);
        for (int i = 0; i < 8; i++)
            if (i != 1 && i != 2) chk(got[i] == 0, "R7 idle channel", int'(got[i]), 0);
        chk(rdy[6] == 0 && rdy[7] == 1, "R7 ready after sweep", int'({rdy[6], rdy[7]}), 1);

        finish_run();
    end
endmodule